// File: doc/BRIEF.md
# D-PHY lane timing calculator

This block turns a lane bit rate, given in Mbps, and a lane selector into the high-speed timing field values a MIPI D-PHY transmitter lane needs. From the rate it derives the byte clock (one eighth of the bit rate) and an escape clock. The escape clock is the byte clock divided by the smallest integer that brings it to 20 MHz or below. Minimum intervals in nanoseconds become clock counts through ceiling divisions. Prepare, zero and trail come from a table banded by rate.

A single start pulse latches the rate and the lane selector. One shared sequential divider then works through ten divisions in a fixed order. When the last one is finished, every field is loaded at once, truncated to its width, and a one-cycle done pulse marks the new values. The fields keep their values until the next done. The clock-lane-only fields carry write strobes that pulse only for the clock lane.

Top module: `lane_tcalc`

## Requirements
- R1: While reset is held, and in the first cycle after it, busy, done, both strobes and every count output are zero.
- R2: A start seen while idle raises busy on the next cycle. The result ends with done high for exactly one cycle, with busy already low in that cycle. All count outputs hold their values in every cycle in which done is low, even when the inputs change.
- R3: With byte clock B = rate·10^6/8 Hz and UI = (1000 + rate/2)/rate (integer division), the counts are ceil(t·B/10^9) for these times: exit t = 120 ns, clock-post t = 70 + 52·UI ns, clock-pre t = 8·UI ns.
- R4: The LPX count is ceil(60·B/10^9), reduced by 2 only when that value is greater than 2.
- R5: The escape divider is D = ceil(B/(20·10^6)) and the escape clock is E = floor(B/D). The turnaround counts are ceil(t·E/10^9), with go t = 240 ns, sure t = 120 ns and wait t = 300 ns.
- R6: Prepare and trail come from the first band whose upper limit is at least the rate. Rates above the last limit use the last band. The bands are, in hex, with limit: prepare/trail: 110: 20/22, 150: 06/45, 200: 18/0B, 250: 05/16, 300: 51/2C, 400: 64/33, 500: 20/4E, 600: 6A/3A, 700: 3E/6A, 800: 21/29, 1000: 09/27.
- R7: Lane code 0 selects the clock lane, and every other code (1 to 7) selects a data lane. The zero count comes from the same band as in R6. For the clock lane the bands give, in order, 16,16,17,17,18,19,1B,1D,1E,1F,20. For a data lane they give 02,03,04,05,06,07,07,08,08,09,09 (hex).
- R8: The post and pre strobes pulse together with done when the latched lane is the clock lane, and stay low for data lanes and at all other times.
- R9: Wakeup-high is 3 and wakeup-low is 0xFF in every result.
- R10: A start that arrives while busy is ignored: the result belongs to the inputs latched at the accepted start.
- R11: A rate of 0 is computed as a rate of 1.
- R12: Every count is truncated to its field width: LPX 6, prepare 7, zero 6, trail 7, exit 5, clock-post 4, clock-pre 4, wakeup-high 2, wakeup-low 8, turnaround 6 bits each. For example, at 2047 Mbps clock-post is 18, which is output as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| rate_mbps | input | RATE_W | Lane bit rate in Mbps |
| lane_sel | input | 3 | 0 = clock lane, other values = data lane |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse when results update |
| post_we | output | 1 | Clock-post write strobe (clock lane only) |
| pre_we | output | 1 | Clock-pre write strobe (clock lane only) |
| lpx_cnt | output | 6 | LPX count |
| prep_cnt | output | 7 | HS prepare value |
| zero_cnt | output | 6 | HS zero value |
| trail_cnt | output | 7 | HS trail value |
| exit_cnt | output | 5 | HS exit count |
| post_cnt | output | 4 | Clock-post count |
| pre_cnt | output | 4 | Clock-pre count |
| wake_hi_cnt | output | 2 | Wakeup high value |
| wake_lo_cnt | output | 8 | Wakeup low value |
| tgo_cnt | output | 6 | Turnaround go count |
| tsure_cnt | output | 6 | Turnaround sure count |
| twait_cnt | output | 6 | Turnaround wait count |

## Verification
The hardest cases to reach are at the edges of the arithmetic. These are the rates where a ceiling flips, the escape divider steps from 1 to 2 between 160 and 161 Mbps, the LPX count crosses its reduce-by-2 threshold near 266 Mbps, and at the top of the range clock-post overflows its four bits. The stimulus sweeps the rate range in fixed steps and adds every band limit and the rate just above it, plus the named edge rates. It cycles through the lane codes, including an out-of-range data code. Each result is compared with a model that works in hertz rather than in the design's reduced fractions. A start pulse in the middle of a calculation and input changes after done cover the ignore and hold rules.

// File: rtl/lane_tcalc_pkg.sv
package lane_tcalc_pkg;

  localparam int NBAND   = 11;
  localparam int BAND_SW = $clog2(NBAND);

  localparam int W_LPX   = 6;
  localparam int W_PREP  = 7;
  localparam int W_ZERO  = 6;
  localparam int W_TRAIL = 7;
  localparam int W_EXIT  = 5;
  localparam int W_POST  = 4;
  localparam int W_PRE   = 4;
  localparam int W_WKH   = 2;
  localparam int W_WKL   = 8;
  localparam int W_TA    = 6;

  localparam logic [W_WKH-1:0] WAKE_HI_VAL = 2'd3;
  localparam logic [W_WKL-1:0] WAKE_LO_VAL = 8'hFF;

  // byte clock per Mbps is 125 kHz, so t*B/1e9 reduces to t*rate/8000
  localparam longint unsigned BYTE_DEN    = 64'd8000;
  localparam longint unsigned HZ_PER_MBPS = 64'd125000;
  localparam longint unsigned ESC_RATIO   = 64'd160;   // 20 MHz / 125 kHz
  localparam longint unsigned NS_PER_S    = 64'd1000000000;

  localparam longint unsigned T_EXIT_NS   = 64'd120;
  localparam longint unsigned T_LPX_NS    = 64'd60;
  localparam longint unsigned T_POST_BASE = 64'd70;
  localparam longint unsigned T_POST_UI   = 64'd52;
  localparam longint unsigned T_PRE_UI    = 64'd8;
  localparam longint unsigned T_GO_NS     = 4 * T_LPX_NS;
  localparam longint unsigned T_SURE_NS   = 2 * T_LPX_NS;
  localparam longint unsigned T_GET_NS    = 5 * T_LPX_NS;

  typedef enum logic [3:0] {
    ST_ESCDIV, ST_ESCCLK, ST_UI, ST_EXIT, ST_POST,
    ST_PRE, ST_LPX, ST_TAGO, ST_TASURE, ST_TAWAIT
  } step_e;

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_FIN} phase_e;

  typedef struct packed {
    logic [W_PREP-1:0]  prep;
    logic [W_ZERO-1:0]  zclk;
    logic [W_ZERO-1:0]  zdat;
    logic [W_TRAIL-1:0] trail;
  } band_t;

  function automatic int unsigned band_limit(input int idx);
    case (idx)
      0: return 110;
      1: return 150;
      2: return 200;
      3: return 250;
      4: return 300;
      5: return 400;
      6: return 500;
      7: return 600;
      8: return 700;
      9: return 800;
      default: return 1000;
    endcase
  endfunction

  function automatic band_t band_entry(input logic [BAND_SW-1:0] idx);
    band_t b;
    case (idx)
      4'd0:    b = '{prep: 7'h20, zclk: 6'h16, zdat: 6'h02, trail: 7'h22};
      4'd1:    b = '{prep: 7'h06, zclk: 6'h16, zdat: 6'h03, trail: 7'h45};
      4'd2:    b = '{prep: 7'h18, zclk: 6'h17, zdat: 6'h04, trail: 7'h0B};
      4'd3:    b = '{prep: 7'h05, zclk: 6'h17, zdat: 6'h05, trail: 7'h16};
      4'd4:    b = '{prep: 7'h51, zclk: 6'h18, zdat: 6'h06, trail: 7'h2C};
      4'd5:    b = '{prep: 7'h64, zclk: 6'h19, zdat: 6'h07, trail: 7'h33};
      4'd6:    b = '{prep: 7'h20, zclk: 6'h1B, zdat: 6'h07, trail: 7'h4E};
      4'd7:    b = '{prep: 7'h6A, zclk: 6'h1D, zdat: 6'h08, trail: 7'h3A};
      4'd8:    b = '{prep: 7'h3E, zclk: 6'h1E, zdat: 6'h08, trail: 7'h6A};
      4'd9:    b = '{prep: 7'h21, zclk: 6'h1F, zdat: 6'h09, trail: 7'h29};
      default: b = '{prep: 7'h09, zclk: 6'h20, zdat: 6'h09, trail: 7'h27};
    endcase
    return b;
  endfunction

  // dividend of each step; ceilings are formed as (a + d - 1) / d
  function automatic logic [63:0] step_num(input step_e s, input logic [63:0] m,
                                           input logic [63:0] ui, input logic [63:0] esc);
    case (s)
      ST_ESCDIV: return m + ESC_RATIO - 1;
      ST_ESCCLK: return m * HZ_PER_MBPS;
      ST_UI:     return 64'd1000 + (m >> 1);
      ST_EXIT:   return T_EXIT_NS * m + BYTE_DEN - 1;
      ST_POST:   return (T_POST_BASE + T_POST_UI * ui) * m + BYTE_DEN - 1;
      ST_PRE:    return T_PRE_UI * ui * m + BYTE_DEN - 1;
      ST_LPX:    return T_LPX_NS * m + BYTE_DEN - 1;
      ST_TAGO:   return T_GO_NS * esc + NS_PER_S - 1;
      ST_TASURE: return T_SURE_NS * esc + NS_PER_S - 1;
      default:   return T_GET_NS * esc + NS_PER_S - 1;
    endcase
  endfunction

  function automatic logic [63:0] step_den(input step_e s, input logic [63:0] m,
                                           input logic [63:0] escdiv);
    case (s)
      ST_ESCDIV: return ESC_RATIO;
      ST_ESCCLK: return escdiv;
      ST_UI:     return m;
      ST_EXIT, ST_POST, ST_PRE, ST_LPX: return BYTE_DEN;
      default:   return NS_PER_S;
    endcase
  endfunction

endpackage

// File: rtl/lane_tcalc_band.sv
module lane_tcalc_band
  import lane_tcalc_pkg::*;
#(
  parameter int RATE_W = 11
) (
  input  logic [RATE_W-1:0]  rate,
  input  logic               clk_lane,
  output logic [W_PREP-1:0]  prep,
  output logic [W_ZERO-1:0]  zero,
  output logic [W_TRAIL-1:0] trail
);

  logic [NBAND-1:0]   fits;
  logic [BAND_SW-1:0] sel;
  band_t              ent;

  for (genvar i = 0; i < NBAND; i++) begin : g_band
    assign fits[i] = (32'(rate) <= band_limit(i));
  end

  // lowest band that fits wins; none fitting leaves the last band
  always_comb begin
    sel = BAND_SW'(NBAND - 1);
    for (int i = NBAND - 1; i >= 0; i--) begin
      if (fits[i]) sel = BAND_SW'(i);
    end
  end

  assign ent   = band_entry(sel);
  assign prep  = ent.prep;
  assign zero  = clk_lane ? ent.zclk : ent.zdat;
  assign trail = ent.trail;

endmodule

// File: rtl/lane_tcalc_div.sv
module lane_tcalc_div #(
  parameter int W = 34
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem;
  logic [W-1:0]  den_q;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    shifted;
  logic [W:0]    diff;

  assign shifted = {rem, quo[W-1]};
  assign diff    = shifted - {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      den_q <= '0;
      quo   <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
    end else if (start) begin
      rem   <= '0;
      den_q <= den;
      quo   <= num;
      cnt   <= CW'(W);
      run   <= 1'b1;
      done  <= 1'b0;
    end else if (run) begin
      if (!diff[W]) begin
        rem <= diff[W-1:0];
        quo <= {quo[W-2:0], 1'b1};
      end else begin
        rem <= shifted[W-1:0];
        quo <= {quo[W-2:0], 1'b0};
      end
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        run  <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

endmodule

// File: rtl/lane_tcalc.sv
module lane_tcalc
  import lane_tcalc_pkg::*;
#(
  parameter int RATE_W = 11,
  parameter int DIV_W  = 34
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RATE_W-1:0]  rate_mbps,
  input  logic [2:0]         lane_sel,
  output logic               busy,
  output logic               done,
  output logic               post_we,
  output logic               pre_we,
  output logic [W_LPX-1:0]   lpx_cnt,
  output logic [W_PREP-1:0]  prep_cnt,
  output logic [W_ZERO-1:0]  zero_cnt,
  output logic [W_TRAIL-1:0] trail_cnt,
  output logic [W_EXIT-1:0]  exit_cnt,
  output logic [W_POST-1:0]  post_cnt,
  output logic [W_PRE-1:0]   pre_cnt,
  output logic [W_WKH-1:0]   wake_hi_cnt,
  output logic [W_WKL-1:0]   wake_lo_cnt,
  output logic [W_TA-1:0]    tgo_cnt,
  output logic [W_TA-1:0]    tsure_cnt,
  output logic [W_TA-1:0]    twait_cnt
);

  phase_e             phase;
  step_e              step;
  logic               issue;
  logic [RATE_W-1:0]  rate_q;
  logic               lane_clk_q;
  logic [DIV_W-1:0]   escdiv_q, escclk_q, ui_q;

  logic [W_EXIT-1:0]  exit_w;
  logic [W_POST-1:0]  post_w;
  logic [W_PRE-1:0]   pre_w;
  logic [W_LPX-1:0]   lpx_w;
  logic [W_TA-1:0]    tgo_w, tsure_w, twait_w;

  // named internal events for the checker
  logic               div_start;
  logic               div_done;
  logic [DIV_W-1:0]   div_num;
  logic [DIV_W-1:0]   div_den;
  logic [DIV_W-1:0]   div_quo;
  logic               accept;
  logic               last_step;

  logic [W_PREP-1:0]  band_prep;
  logic [W_ZERO-1:0]  band_zero;
  logic [W_TRAIL-1:0] band_trail;

  assign busy      = (phase != PH_IDLE);
  assign accept    = start && (phase == PH_IDLE);
  assign div_start = (phase == PH_RUN) && issue;
  assign last_step = (step == ST_TAWAIT);
  assign div_num   = DIV_W'(step_num(step, 64'(rate_q), 64'(ui_q), 64'(escclk_q)));
  assign div_den   = DIV_W'(step_den(step, 64'(rate_q), 64'(escdiv_q)));

  lane_tcalc_div #(.W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .done  (div_done),
    .quo   (div_quo)
  );

  lane_tcalc_band #(.RATE_W(RATE_W)) u_band (
    .rate     (rate_q),
    .clk_lane (lane_clk_q),
    .prep     (band_prep),
    .zero     (band_zero),
    .trail    (band_trail)
  );

  // sequencing and capture of intermediate quotients
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      step       <= ST_ESCDIV;
      issue      <= 1'b0;
      rate_q     <= '0;
      lane_clk_q <= 1'b0;
      escdiv_q   <= '0;
      escclk_q   <= '0;
      ui_q       <= '0;
      exit_w     <= '0;
      post_w     <= '0;
      pre_w      <= '0;
      lpx_w      <= '0;
      tgo_w      <= '0;
      tsure_w    <= '0;
      twait_w    <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            rate_q     <= (rate_mbps == '0) ? RATE_W'(1) : rate_mbps;
            lane_clk_q <= (lane_sel == 3'd0);
            step       <= ST_ESCDIV;
            issue      <= 1'b1;
            phase      <= PH_RUN;
          end
        end
        PH_RUN: begin
          if (issue) issue <= 1'b0;
          if (div_done) begin
            case (step)
              ST_ESCDIV: escdiv_q <= div_quo;
              ST_ESCCLK: escclk_q <= div_quo;
              ST_UI:     ui_q     <= div_quo;
              ST_EXIT:   exit_w   <= W_EXIT'(div_quo);
              ST_POST:   post_w   <= W_POST'(div_quo);
              ST_PRE:    pre_w    <= W_PRE'(div_quo);
              ST_LPX:    lpx_w    <= (div_quo > DIV_W'(2)) ? W_LPX'(div_quo - DIV_W'(2))
                                                           : W_LPX'(div_quo);
              ST_TAGO:   tgo_w    <= W_TA'(div_quo);
              ST_TASURE: tsure_w  <= W_TA'(div_quo);
              default:   twait_w  <= W_TA'(div_quo);
            endcase
            if (last_step) begin
              phase <= PH_FIN;
            end else begin
              step  <= step_e'(step + 4'd1);
              issue <= 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // presentation: all fields load together with the done pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      post_we     <= 1'b0;
      pre_we      <= 1'b0;
      lpx_cnt     <= '0;
      prep_cnt    <= '0;
      zero_cnt    <= '0;
      trail_cnt   <= '0;
      exit_cnt    <= '0;
      post_cnt    <= '0;
      pre_cnt     <= '0;
      wake_hi_cnt <= '0;
      wake_lo_cnt <= '0;
      tgo_cnt     <= '0;
      tsure_cnt   <= '0;
      twait_cnt   <= '0;
    end else if (phase == PH_FIN) begin
      done        <= 1'b1;
      post_we     <= lane_clk_q;
      pre_we      <= lane_clk_q;
      lpx_cnt     <= lpx_w;
      prep_cnt    <= band_prep;
      zero_cnt    <= band_zero;
      trail_cnt   <= band_trail;
      exit_cnt    <= exit_w;
      post_cnt    <= post_w;
      pre_cnt     <= pre_w;
      wake_hi_cnt <= WAKE_HI_VAL;
      wake_lo_cnt <= WAKE_LO_VAL;
      tgo_cnt     <= tgo_w;
      tsure_cnt   <= tsure_w;
      twait_cnt   <= twait_w;
    end else begin
      done    <= 1'b0;
      post_we <= 1'b0;
      pre_we  <= 1'b0;
    end
  end

endmodule

// File: rtl/lane_tcalc_chk.sv
module lane_tcalc_chk
  import lane_tcalc_pkg::*;
#(
  parameter int RATE_W = 11,
  parameter int DIV_W  = 34
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               post_we,
  input logic               pre_we,
  input logic               lane_clk_q,
  input logic [RATE_W-1:0]  rate_q,
  input logic               div_start,
  input logic [DIV_W-1:0]   div_den,
  input logic [W_LPX-1:0]   lpx_cnt,
  input logic [W_PREP-1:0]  prep_cnt,
  input logic [W_ZERO-1:0]  zero_cnt,
  input logic [W_TRAIL-1:0] trail_cnt,
  input logic [W_EXIT-1:0]  exit_cnt,
  input logic [W_POST-1:0]  post_cnt,
  input logic [W_PRE-1:0]   pre_cnt,
  input logic [W_WKH-1:0]   wake_hi_cnt,
  input logic [W_WKL-1:0]   wake_lo_cnt,
  input logic [W_TA-1:0]    tgo_cnt,
  input logic [W_TA-1:0]    tsure_cnt,
  input logic [W_TA-1:0]    twait_cnt
);

  logic [W_LPX+W_PREP+W_ZERO+W_TRAIL+W_EXIT+W_POST+W_PRE+W_WKH+W_WKL+3*W_TA-1:0] all_cnt;
  assign all_cnt = {lpx_cnt, prep_cnt, zero_cnt, trail_cnt, exit_cnt, post_cnt,
                    pre_cnt, wake_hi_cnt, wake_lo_cnt, tgo_cnt, tsure_cnt, twait_cnt};

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(all_cnt));

  p_strobe_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (post_we == lane_clk_q) && (pre_we == lane_clk_q));

  p_strobe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!post_we && !pre_we));

  p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wake_hi_cnt == 2'd3) && (wake_lo_cnt == 8'hFF));

  p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(rate_q));

  p_den_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |-> (div_den != '0));

  p_rate_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rate_q != '0));

endmodule

bind lane_tcalc lane_tcalc_chk #(.RATE_W(RATE_W), .DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .post_we     (post_we),
  .pre_we      (pre_we),
  .lane_clk_q  (lane_clk_q),
  .rate_q      (rate_q),
  .div_start   (div_start),
  .div_den     (div_den),
  .lpx_cnt     (lpx_cnt),
  .prep_cnt    (prep_cnt),
  .zero_cnt    (zero_cnt),
  .trail_cnt   (trail_cnt),
  .exit_cnt    (exit_cnt),
  .post_cnt    (post_cnt),
  .pre_cnt     (pre_cnt),
  .wake_hi_cnt (wake_hi_cnt),
  .wake_lo_cnt (wake_lo_cnt),
  .tgo_cnt     (tgo_cnt),
  .tsure_cnt   (tsure_cnt),
  .twait_cnt   (twait_cnt)
);

// File: tb/lane_tcalc_test.sv
module lane_tcalc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [10:0] rate_mbps = '0;
  logic [2:0]  lane_sel = '0;
  logic        busy, done, post_we, pre_we;
  logic [5:0]  lpx_cnt, zero_cnt, tgo_cnt, tsure_cnt, twait_cnt;
  logic [6:0]  prep_cnt, trail_cnt;
  logic [4:0]  exit_cnt;
  logic [3:0]  post_cnt, pre_cnt;
  logic [1:0]  wake_hi_cnt;
  logic [7:0]  wake_lo_cnt;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  lane_tcalc uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_mbps(rate_mbps), .lane_sel(lane_sel),
    .busy(busy), .done(done), .post_we(post_we), .pre_we(pre_we),
    .lpx_cnt(lpx_cnt), .prep_cnt(prep_cnt), .zero_cnt(zero_cnt), .trail_cnt(trail_cnt),
    .exit_cnt(exit_cnt), .post_cnt(post_cnt), .pre_cnt(pre_cnt),
    .wake_hi_cnt(wake_hi_cnt), .wake_lo_cnt(wake_lo_cnt),
    .tgo_cnt(tgo_cnt), .tsure_cnt(tsure_cnt), .twait_cnt(twait_cnt)
  );

  // band table kept per column: upper limit, prepare, trail, clock zero, data zero
  int lim[11], bprep[11], btrail[11], bzc[11], bzd[11];
  initial begin
    lim    = '{110, 150, 200, 250, 300, 400, 500, 600, 700, 800, 1000};
    bprep  = '{'h20, 'h06, 'h18, 'h05, 'h51, 'h64, 'h20, 'h6A, 'h3E, 'h21, 'h09};
    btrail = '{'h22, 'h45, 'h0B, 'h16, 'h2C, 'h33, 'h4E, 'h3A, 'h6A, 'h29, 'h27};
    bzc    = '{'h16, 'h16, 'h17, 'h17, 'h18, 'h19, 'h1B, 'h1D, 'h1E, 'h1F, 'h20};
    bzd    = '{'h02, 'h03, 'h04, 'h05, 'h06, 'h07, 'h07, 'h08, 'h08, 'h09, 'h09};
  end

  longint e_lpx, e_prep, e_zero, e_trail, e_exit, e_post, e_pre, e_go, e_sure, e_wait;
  bit     e_clk;

  function automatic longint ceil_cnt(longint t_ns, longint f_hz);
    return (t_ns * f_hz + 64'd999999999) / 64'd1000000000;
  endfunction

  task automatic model(input int r_in, input int lane);
    longint m, bc, ed, esc, ui, raw;
    int b;
    m   = (r_in == 0) ? 1 : r_in;
    bc  = m * 1000000 / 8;
    ed  = (bc + 19999999) / 20000000;
    esc = bc / ed;
    ui  = (1000 + m / 2) / m;
    e_exit = ceil_cnt(120, bc) % 32;
    e_post = ceil_cnt(70 + 52 * ui, bc) % 16;
    e_pre  = ceil_cnt(8 * ui, bc) % 16;
    raw    = ceil_cnt(60, bc);
    if (raw > 2) raw = raw - 2;
    e_lpx  = raw % 64;
    e_go   = ceil_cnt(240, esc) % 64;
    e_sure = ceil_cnt(120, esc) % 64;
    e_wait = ceil_cnt(300, esc) % 64;
    b = 10;
    for (int i = 10; i >= 0; i--) if (m <= lim[i]) b = i;
    e_clk   = (lane == 0);
    e_prep  = bprep[b];
    e_trail = btrail[b];
    e_zero  = e_clk ? bzc[b] : bzd[b];
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare(input int r, input bit at_done);
    chk(exit_cnt == e_exit, "R3", $sformatf("exit @%0d", r), exit_cnt, e_exit);
    chk(post_cnt == e_post, "R3", $sformatf("post @%0d", r), post_cnt, e_post);
    chk(pre_cnt  == e_pre,  "R3", $sformatf("pre @%0d", r), pre_cnt, e_pre);
    chk(lpx_cnt  == e_lpx,  "R4", $sformatf("lpx @%0d", r), lpx_cnt, e_lpx);
    chk(tgo_cnt  == e_go,   "R5", $sformatf("ta_go @%0d", r), tgo_cnt, e_go);
    chk(tsure_cnt == e_sure, "R5", $sformatf("ta_sure @%0d", r), tsure_cnt, e_sure);
    chk(twait_cnt == e_wait, "R5", $sformatf("ta_wait @%0d", r), twait_cnt, e_wait);
    chk(prep_cnt == e_prep, "R6", $sformatf("prepare @%0d", r), prep_cnt, e_prep);
    chk(trail_cnt == e_trail, "R6", $sformatf("trail @%0d", r), trail_cnt, e_trail);
    chk(zero_cnt == e_zero, "R7", $sformatf("zero @%0d", r), zero_cnt, e_zero);
    chk(wake_hi_cnt == 2'd3 && wake_lo_cnt == 8'hFF, "R9", "wakeup",
        {wake_hi_cnt, wake_lo_cnt}, 10'h3FF);
    if (at_done) begin
      chk(post_we == e_clk && pre_we == e_clk, "R8", "strobes at done",
          {post_we, pre_we}, {e_clk, e_clk});
      chk(busy == 1'b0, "R2", "busy low with done", busy, 0);
    end else begin
      chk(post_we == 1'b0 && pre_we == 1'b0, "R8", "strobes idle", {post_we, pre_we}, 0);
    end
  endtask

  task automatic wait_done(output bit seen);
    int n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    seen = done;
    if (!seen) chk(1'b0, "R2", "done timeout", 0, 1);
  endtask

  task automatic go(input int r, input int lane);
    bit seen;
    @(negedge clk);
    rate_mbps = r[10:0];
    lane_sel  = lane[2:0];
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    wait_done(seen);
    model(r, lane);
    if (seen) begin
      compare(r, 1'b1);
      @(negedge clk);
      chk(done == 1'b0, "R2", "done single cycle", done, 0);
    end
  endtask

  initial begin
    bit seen;
    int k;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && post_we == 0 && pre_we == 0, "R1", "reset controls",
        {busy, done, post_we, pre_we}, 0);
    chk({lpx_cnt, prep_cnt, zero_cnt, trail_cnt, exit_cnt, post_cnt, pre_cnt,
         wake_hi_cnt, wake_lo_cnt, tgo_cnt, tsure_cnt, twait_cnt} == '0, "R1",
        "reset counts", lpx_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && wake_lo_cnt == 0, "R1", "after reset release",
        {busy, done}, 0);

    // edge rates
    go(160, 1);  go(161, 1);           // escape divider 1 -> 2 (R5)
    go(266, 2);  go(267, 2);           // lpx reduction threshold (R4)
    go(133, 0);                         // small lpx kept as is (R4)
    go(0, 0);                           // rate 0 acts as 1 (R11)
    chk(post_cnt == 4'd7, "R11", "post at rate 0", post_cnt, 7);
    go(2047, 0);                        // truncation (R12)
    chk(post_cnt == 4'd2, "R12", "post truncated at 2047", post_cnt, 2);
    go(1500, 7);                        // out-of-range code is a data lane (R7)
    chk(zero_cnt == 6'h09, "R7", "code 7 data zero", zero_cnt, 9);

    // every band limit and the rate just above it, alternating lanes (R6, R7)
    for (int i = 0; i < 11; i++) begin
      go(lim[i], i % 2 == 0 ? 0 : 3);
      go(lim[i] + 1, i % 2 == 0 ? 4 : 0);
    end

    // swept rates, lane code cycling through all five lanes
    k = 0;
    for (int r = 1; r < 2048; r += 13) begin
      go(r, k % 5);
      k++;
    end

    // start while busy is ignored (R10)
    @(negedge clk);
    rate_mbps = 11'd300; lane_sel = 3'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rate_mbps = 11'd1000; lane_sel = 3'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen);
    model(300, 0);
    if (seen) begin
      chk(zero_cnt == e_zero, "R10", "zero of first request", zero_cnt, e_zero);
      chk(prep_cnt == e_prep, "R10", "prepare of first request", prep_cnt, e_prep);
      chk(post_we == 1'b1, "R10", "clock-lane strobe kept", post_we, 1);
      compare(300, 1'b1);
    end
    @(negedge clk);
    chk(busy == 1'b0, "R10", "no second run", busy, 0);

    // outputs hold without start while inputs move (R2)
    rate_mbps = 11'd50; lane_sel = 3'd4;
    repeat (40) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R2", "idle after input change", {busy, done}, 0);
    compare(300, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule